// File: doc/BRIEF.md
# Status Register Write Controller

This block owns the current program status word and one saved status word for each privileged bank of a processor core. When the execute stage retires a move-to-status instruction, the block receives the instruction's four-bit field mask, the 32-bit source operand, the active bank and a target select. It then merges the operand into the selected register one field at a time. Which field is written depends on a priority decode of the mask and on whether the active bank is privileged. A saved-register write from a bank that has no saved register is dropped.

The register outputs are the current word and a read view of the saved word of the active bank. A bank with no saved register returns the current word instead. The block also drives the decoded condition flags, the two interrupt-disable bits, a privilege indicator and a one-cycle strobe that tells the register bank the mode field has moved. A configuration pin selects 26-bit compatibility. When that pin is low, every write to the current word is trimmed to the fields that the narrow programming model keeps.

Top module: `psr_write_ctrl`

## Requirements
- R1: After synchronous reset the current word is 0x000000D3 (mode 0x13, both interrupt disables set), every saved word is zero and the mode strobe is low.
- R2: With bank 0 (user) active, a write to the current word with mask bit 3 set replaces only bits 31:28 with the operand. Without mask bit 3 the word is unchanged, whatever the other mask bits are.
- R3: With any nonzero bank active, a mask of exactly 4'b1001 replaces all 32 bits of the target word.
- R4: With a nonzero bank and a mask other than 4'b1001, mask bit 0 replaces only bits 7:0 (interrupt disables and mode). Bit 0 wins over bit 3, so mask 4'b1111 writes only bits 7:0.
- R5: With a nonzero bank, mask bit 3 without bit 0 replaces only bits 31:28. A mask with neither bit changes nothing.
- R6: A saved-word write (target select high) follows the privileged rules of R3 to R5 for the saved word of the active bank. Banks 1 to 5 each own one saved word. A saved-word write from bank 0, 6 or 7 changes no stored state. A saved-word write never changes the current word.
- R7: The saved-word output shows the active bank's saved word for banks 1 to 5, and the current word for banks 0, 6 and 7.
- R8: When the 32-bit-program pin is low, the current word after any write holds only bits 31:28, 7:6 and 1:0, and all other bits are cleared.
- R9: The mode strobe is high for exactly the one cycle after a current-word write whose result differs from the previous word in bits 4:0. The privilege output is high whenever either of bits 1:0 of the current word is set.
- R10: The flag outputs N, Z, C and V are bits 31, 30, 29 and 28 of the current word. The IRQ and FIQ disable outputs are bits 7 and 6.
- R11: A write takes effect on the rising clock edge on which the request is sampled high. With no request the stored words hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request, one cycle per instruction |
| wr_saved | input | 1 | Target: 0 current word, 1 saved word of the active bank |
| field_mask | input | 4 | Instruction field mask; bit 0 selects control, bit 3 selects flags |
| src_data | input | 32 | Source operand |
| bank | input | 3 | Active bank: 0 user, 1 to 5 privileged with saved word, 6 and 7 none |
| prog32 | input | 1 | 1: full 32-bit word kept; 0: 26-bit compatible trimming |
| cpsr_q | output | 32 | Current status word |
| spsr_q | output | 32 | Saved word of the active bank, or the current word (R7) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_dis | output | 1 | IRQ disable bit |
| fiq_dis | output | 1 | FIQ disable bit |
| priv | output | 1 | Privilege indicator from mode bits 1:0 |
| mode_chg | output | 1 | One-cycle strobe after a mode change |

## Verification
Every mask shape that decodes differently is tried in both user and privileged banks: flags only, control only, 4'b1001, 4'b1111 and zero. Operands set every bit, so a write to the wrong field shows up as a stray bit. Saved-word writes are sent from each class of bank and then read back after switching banks. This tells an ignored write apart from one that landed in the wrong slot. The 26-bit trimming is tried with an all-ones operand and then turned off again. Writes that keep the mode and writes that change it are interleaved to check that the strobe lasts exactly one cycle.

// File: rtl/psr_pkg.sv
// Shared widths, bank codes and field masks for the status register
// write controller. Assumes the flags occupy the top nibble and the
// control field the low byte of the status word.
package psr_pkg;
    localparam int PSR_W   = 32;
    localparam int MASK_W  = 4;
    localparam int BANK_W  = 3;
    localparam int FLAG_W  = 4;
    localparam int CTRL_W  = 8;
    localparam int MODE_W  = 5;

    typedef enum logic [BANK_W-1:0] {
        BANK_USER = 3'd0,
        BANK_FAST = 3'd1,
        BANK_INT  = 3'd2,
        BANK_SUP  = 3'd3,
        BANK_ABT  = 3'd4,
        BANK_UND  = 3'd5,
        BANK_NIL6 = 3'd6,
        BANK_NIL7 = 3'd7
    } bank_e;

    localparam logic [PSR_W-1:0] FLAG_FIELD  = {{FLAG_W{1'b1}}, {(PSR_W-FLAG_W){1'b0}}};
    localparam logic [PSR_W-1:0] CTRL_FIELD  = {{(PSR_W-CTRL_W){1'b0}}, {CTRL_W{1'b1}}};
    localparam logic [PSR_W-1:0] NARROW_KEEP = 32'hF000_00C3;
    localparam logic [PSR_W-1:0] PSR_RESET   = 32'h0000_00D3;
    localparam logic [MASK_W-1:0] MASK_WHOLE = 4'b1001;
endpackage

// File: rtl/psr_field_merge.sv
// Field merge: decodes the instruction field mask with privilege and
// merges the operand into the old word. Purely combinational.
// Assumes mask bit 0 is the control selector and bit 3 the flag selector.
module psr_field_merge
    import psr_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  logic              privileged,
    input  logic [PSR_W-1:0]  old_val,
    input  logic [PSR_W-1:0]  src_val,
    output logic [PSR_W-1:0]  new_val
);
    logic [PSR_W-1:0] wmask;

    // Priority decode of the field mask into a bit-level write enable.
    always_comb begin
        if (!privileged)
            wmask = mask[MASK_W-1] ? FLAG_FIELD : '0;
        else if (mask == MASK_WHOLE)
            wmask = '1;
        else if (mask[0])
            wmask = CTRL_FIELD;
        else if (mask[MASK_W-1])
            wmask = FLAG_FIELD;
        else
            wmask = '0;
    end

    // Bitwise merge of the selected field.
    always_comb begin
        new_val = (old_val & ~wmask) | (src_val & wmask);
    end
endmodule

// File: rtl/psr_saved_bank.sv
// Saved status words, one per privileged bank code 1..NUM_SAVED.
// Writes to a bank code without a slot are dropped. Read data follows the
// bank select combinationally; has_slot tells whether it is valid.
module psr_saved_bank
    import psr_pkg::*;
#(
    parameter int NUM_SAVED = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] bank,
    input  logic [PSR_W-1:0]  wr_data,
    output logic [PSR_W-1:0]  rd_data,
    output logic              has_slot
);
    logic [PSR_W-1:0] slot_q [NUM_SAVED];

    for (genvar g = 0; g < NUM_SAVED; g++) begin : g_slot
        // One saved word; loads when its bank code is active and written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && bank == BANK_W'(g + 1))
                slot_q[g] <= wr_data;
        end
    end

    // Read mux over the slots.
    always_comb begin
        rd_data  = '0;
        has_slot = 1'b0;
        for (int i = 0; i < NUM_SAVED; i++) begin
            if (bank == BANK_W'(i + 1)) begin
                rd_data  = slot_q[i];
                has_slot = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psr_write_ctrl.sv
// Status register write controller top. Holds the current status word,
// routes move-to-status writes through a field merge to either the current
// word or the active bank's saved word, trims for 26-bit compatibility and
// flags mode changes. Assumes one write request per instruction.
module psr_write_ctrl
    import psr_pkg::*;
#(
    parameter int NUM_SAVED = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_saved,
    input  logic [MASK_W-1:0] field_mask,
    input  logic [PSR_W-1:0]  src_data,
    input  logic [BANK_W-1:0] bank,
    input  logic              prog32,
    output logic [PSR_W-1:0]  cpsr_q,
    output logic [PSR_W-1:0]  spsr_q,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              irq_dis,
    output logic              fiq_dis,
    output logic              priv,
    output logic              mode_chg
);
    logic [PSR_W-1:0] cur_merged;
    logic [PSR_W-1:0] cur_kept;
    logic [PSR_W-1:0] sav_old;
    logic [PSR_W-1:0] sav_merged;
    logic             sav_has_slot;
    logic             cur_priv;
    logic             cur_wr;

    assign cur_priv = (bank != BANK_USER);
    assign cur_wr   = wr_en && !wr_saved;

    psr_field_merge u_merge_cur (
        .mask       (field_mask),
        .privileged (cur_priv),
        .old_val    (cpsr_q),
        .src_val    (src_data),
        .new_val    (cur_merged)
    );

    psr_field_merge u_merge_sav (
        .mask       (field_mask),
        .privileged (1'b1),
        .old_val    (sav_old),
        .src_val    (src_data),
        .new_val    (sav_merged)
    );

    psr_saved_bank #(.NUM_SAVED(NUM_SAVED)) u_saved (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && wr_saved),
        .bank     (bank),
        .wr_data  (sav_merged),
        .rd_data  (sav_old),
        .has_slot (sav_has_slot)
    );

    // Trim the merged word when running the narrow programming model.
    always_comb begin
        cur_kept = prog32 ? cur_merged : (cur_merged & NARROW_KEEP);
    end

    // Current status word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpsr_q <= PSR_RESET;
        else if (cur_wr)
            cpsr_q <= cur_kept;
    end

    // One-cycle strobe when a write moves the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_chg <= 1'b0;
        else
            mode_chg <= cur_wr && (cur_kept[MODE_W-1:0] != cpsr_q[MODE_W-1:0]);
    end

    assign spsr_q  = sav_has_slot ? sav_old : cpsr_q;
    assign flag_n  = cpsr_q[PSR_W-1];
    assign flag_z  = cpsr_q[PSR_W-2];
    assign flag_c  = cpsr_q[PSR_W-3];
    assign flag_v  = cpsr_q[PSR_W-4];
    assign irq_dis = cpsr_q[7];
    assign fiq_dis = cpsr_q[6];
    assign priv    = |cpsr_q[1:0];
endmodule

// File: rtl/psr_write_ctrl_sva.sv
// Checker for psr_write_ctrl: port-level temporal properties. Attached
// to every instance of the top by the bind at the end of this file.
module psr_write_ctrl_sva
    import psr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_saved,
    input logic [MASK_W-1:0] field_mask,
    input logic [PSR_W-1:0]  src_data,
    input logic [BANK_W-1:0] bank,
    input logic              prog32,
    input logic [PSR_W-1:0]  cpsr_q,
    input logic [PSR_W-1:0]  spsr_q,
    input logic              mode_chg
);
    // R11: no request, current word holds.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cpsr_q));

    // R2: user bank writes never touch bits below the flags.
    p_user_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_saved && bank == BANK_USER && prog32)
        |=> cpsr_q[PSR_W-5:0] == $past(cpsr_q[PSR_W-5:0]));

    // R3: whole-word write in a privileged bank.
    p_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_saved && bank != BANK_USER && field_mask == MASK_WHOLE && prog32)
        |=> cpsr_q == $past(src_data));

    // R4: control-only write leaves everything above the low byte alone.
    p_ctrl_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_saved && bank != BANK_USER && field_mask[0]
         && field_mask != MASK_WHOLE && prog32)
        |=> cpsr_q[PSR_W-1:8] == $past(cpsr_q[PSR_W-1:8]));

    // R6: saved-word writes never change the current word.
    p_saved_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_saved) |=> $stable(cpsr_q));

    // R7: banks without a saved word show the current word.
    p_saved_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BANK_USER || bank == BANK_NIL6 || bank == BANK_NIL7) |-> spsr_q == cpsr_q);

    // R8: narrow model trims every current-word write.
    p_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_saved && !prog32) |=> (cpsr_q & ~NARROW_KEEP) == '0);

    // R9: the strobe only follows a current-word write.
    p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> $past(wr_en && !wr_saved));

    // R9: the strobe implies the mode field moved.
    p_strobe_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> cpsr_q[MODE_W-1:0] != $past(cpsr_q[MODE_W-1:0]));
endmodule

bind psr_write_ctrl psr_write_ctrl_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_saved   (wr_saved),
    .field_mask (field_mask),
    .src_data   (src_data),
    .bank       (bank),
    .prog32     (prog32),
    .cpsr_q     (cpsr_q),
    .spsr_q     (spsr_q),
    .mode_chg   (mode_chg)
);

// File: tb/psr_write_ctrl_test.sv
module psr_write_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_saved = 1'b0;
    logic [3:0]  field_mask = '0;
    logic [31:0] src_data = '0;
    logic [2:0]  bank = '0;
    logic        prog32 = 1'b1;
    logic [31:0] cpsr_q, spsr_q;
    logic        flag_n, flag_z, flag_c, flag_v, irq_dis, fiq_dis, priv, mode_chg;

    psr_write_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_saved(wr_saved),
        .field_mask(field_mask), .src_data(src_data), .bank(bank), .prog32(prog32),
        .cpsr_q(cpsr_q), .spsr_q(spsr_q), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v), .irq_dis(irq_dis), .fiq_dis(fiq_dis),
        .priv(priv), .mode_chg(mode_chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] cpsr;
        logic [31:0] spsr;
        logic        mchg;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0;
    int          fails = 0;
    logic [31:0] m_cpsr = 32'h0000_00D3;
    logic [31:0] m_sav [8];

    // Reference merge written from R2..R5.
    function automatic logic [31:0] ref_merge(input logic [3:0] m, input bit pr,
                                              input logic [31:0] o, input logic [31:0] s);
        logic [31:0] w;
        if (!pr)              w = m[3] ? 32'hF000_0000 : 32'h0;
        else if (m == 4'b1001) w = 32'hFFFF_FFFF;
        else if (m[0])        w = 32'h0000_00FF;
        else if (m[3])        w = 32'hF000_0000;
        else                  w = 32'h0;
        return (o & ~w) | (s & w);
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic drive(input bit en, input bit sv, input logic [3:0] m,
                         input logic [31:0] s, input logic [2:0] b, input bit p32,
                         input string tag);
        exp_t        e;
        logic [31:0] nxt;
        @(negedge clk); #1;
        wr_en = en; wr_saved = sv; field_mask = m; src_data = s; bank = b; prog32 = p32;
        e.mchg = 1'b0;
        if (en && !sv) begin
            nxt = ref_merge(m, b != 3'd0, m_cpsr, s);
            if (!p32) nxt = nxt & 32'hF000_00C3;
            e.mchg = (nxt[4:0] != m_cpsr[4:0]);
            m_cpsr = nxt;
        end
        if (en && sv && b >= 3'd1 && b <= 3'd5)
            m_sav[b] = ref_merge(m, 1'b1, m_sav[b], s);
        e.cpsr = m_cpsr;
        e.spsr = (b >= 3'd1 && b <= 3'd5) ? m_sav[b] : m_cpsr;
        e.tag  = tag;
        @(posedge clk);
        sbq.push_back(e);
        #1 wr_en = 1'b0;
    endtask

    // Monitor: pops expectations and compares at the falling edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            logic [39:0] got, exp;
            e   = sbq.pop_front();
            got = {cpsr_q, mode_chg, priv, flag_n, flag_z, flag_c, flag_v, irq_dis, fiq_dis};
            exp = {e.cpsr, e.mchg, |e.cpsr[1:0], e.cpsr[31:28], e.cpsr[7], e.cpsr[6]};
            checks++;
            if (got !== exp || spsr_q !== e.spsr) begin
                fails++;
                $display("FAIL %s: actual word/strobe/priv/flags=%h saved=%h expected %h saved=%h",
                         e.tag, got, spsr_q, exp, e.spsr);
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R11: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_sav[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state, checked at the ports.
        checks++;
        if (cpsr_q !== 32'h0000_00D3 || mode_chg !== 1'b0 || spsr_q !== 32'h0000_00D3
            || priv !== 1'b1 || irq_dis !== 1'b1 || fiq_dis !== 1'b1) begin
            fails++;
            $display("FAIL R1: actual %h/%b expected 000000d3/0", cpsr_q, mode_chg);
        end

        drive(1, 0, 4'b1001, 32'h8000_0010, 3'd3, 1, "R3 whole word, R9 mode moves");
        drive(0, 0, 4'b0000, 32'hFFFF_FFFF, 3'd3, 1, "R11 idle hold, R9 strobe drops");
        drive(1, 0, 4'b1000, 32'h5FFF_FFFF, 3'd0, 1, "R2 user flags");
        drive(1, 0, 4'b0001, 32'hFFFF_FFFF, 3'd0, 1, "R2 user control ignored");
        drive(1, 0, 4'b1001, 32'hA000_00FF, 3'd0, 1, "R2 user whole mask flags only");
        drive(1, 0, 4'b1111, 32'h3333_33D1, 3'd3, 1, "R4 control priority over flags");
        drive(1, 0, 4'b1000, 32'h6ABC_DEFF, 3'd2, 1, "R5 privileged flags only");
        drive(1, 0, 4'b0001, 32'hFFFF_FF13, 3'd2, 1, "R4 control only");
        drive(1, 0, 4'b0000, 32'hFFFF_FFFF, 3'd4, 1, "R5 empty mask no change");
        drive(1, 1, 4'b1001, 32'h1234_5678, 3'd3, 1, "R6 saved whole");
        drive(1, 1, 4'b0001, 32'hAAAA_AAAA, 3'd2, 1, "R6 saved control");
        drive(1, 1, 4'b1000, 32'hF000_0000, 3'd2, 1, "R6 saved flags");
        drive(1, 1, 4'b1001, 32'hDEAD_BEEF, 3'd0, 1, "R6 user saved ignored, R7 view");
        drive(1, 1, 4'b1001, 32'hCAFE_F00D, 3'd6, 1, "R6 dummy saved ignored, R7 view");
        drive(0, 0, 4'b0000, 32'h0, 3'd3, 1, "R6 readback bank 3");
        drive(0, 0, 4'b0000, 32'h0, 3'd2, 1, "R6 readback bank 2");
        drive(0, 0, 4'b0000, 32'h0, 3'd1, 1, "R6 untouched bank 1");
        drive(0, 0, 4'b0000, 32'h0, 3'd7, 1, "R7 bank 7 view");
        drive(1, 0, 4'b1001, 32'hFFFF_FFFF, 3'd3, 0, "R8 narrow trim");
        drive(1, 0, 4'b1000, 32'h0000_0000, 3'd0, 0, "R8 narrow user flags");
        drive(1, 0, 4'b1001, 32'h0000_0110, 3'd5, 1, "R10 flags and disables clear, R9");
        drive(0, 0, 4'b0000, 32'h0, 3'd5, 1, "R11 final hold");

        while (sbq.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        summary();
        $finish;
    end
endmodule